// File: doc/BRIEF.md
# Shared-Memory Doorbell and Interrupt Register Block

This block is the 32-bit control window of a device through which several nodes share one memory region. Software on the local node uses it in two ways. It reads and acknowledges local interrupts through a mask register and a status register, and the status register empties itself when it is read. It also rings a remote node by writing a doorbell word that names a target node and a vector. An own-ID register reports the node number that was assigned to this node.

The block raises a level interrupt whenever the status and mask registers share a set bit. An external event port can load the status register directly. A doorbell write is broken into a destination ID and a vector number. Both are range-checked against a live peer table that lies outside the block. A write that passes produces a one-cycle notify strobe that carries the destination and the vector. A write that fails is dropped without any trace.

Top module: `shm_doorbell_regs`

## Requirements
- R1: After reset the mask and status registers read zero, `irq` is low and `notify_valid` is low.
- R2: A write whose address, with bits [1:0] ignored, equals 0x0 loads the mask register. A read at exactly 0x0 returns the mask.
- R3: `irq` is high exactly when (status AND mask) is nonzero. It follows every mask write, status write, status read and event in the cycle after the access.
- R4: A read at exactly 0x4 returns the current status value and clears the status register to zero, so `irq` drops.
- R5: A write whose address, with bits [1:0] ignored, equals 0x4 loads the status register with the write data.
- R6: A read at exactly 0x8 returns the zero-extended `node_id` while `mem_mapped` is high, and 0xFFFFFFFF while it is low.
- R7: A read of any other offset returns zero, including unaligned offsets such as 0x5 and the doorbell offset 0xC. A write to an offset other than 0x0, 0x4 and 0xC leaves the mask and status registers unchanged.
- R8: A write whose address, with bits [1:0] ignored, equals 0xC is a doorbell. Its destination is data bits [31:16] and its vector is bits [7:0]; bits [15:8] are ignored. A doorbell that passes the checks drives `notify_valid` high for one cycle, with `notify_dest` and `notify_vec`, in the cycle after the write.
- R9: A doorbell whose destination is greater than `pt_max_id` produces no notify.
- R10: A doorbell whose vector is not less than `pt_vec_count` produces no notify. `pt_vec_count` is the vector count that the table returns for `pt_query_id`, which equals write data bits [31:16]. A count of zero rejects every vector.
- R11: `evt_valid` loads `evt_value` into the status register. It takes priority over a status read or a status write in the same cycle, and such a read still returns the old status.
- R12: Read data and `rd_valid` appear in the cycle after a read access. `rd_valid` is high only then.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Register access strobe |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 8 | Byte offset within the 256-byte window |
| acc_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| node_id | input | 16 | Node number assigned to this node |
| mem_mapped | input | 1 | Shared memory is mapped |
| evt_valid | input | 1 | Incoming event strobe |
| evt_value | input | 32 | Value loaded into status on an event |
| pt_query_id | output | 16 | Peer ID looked up in the peer table |
| pt_max_id | input | 16 | Highest valid peer ID |
| pt_vec_count | input | 9 | Vector count of the queried peer |
| irq | output | 1 | Level interrupt |
| notify_valid | output | 1 | Doorbell accepted strobe |
| notify_dest | output | 16 | Destination of the accepted doorbell |
| notify_vec | output | 8 | Vector of the accepted doorbell |

## Verification
The hardest case to reach is an event that lands in the same cycle as a status read. The read must still return the old value, while the event value survives in place of the clear. The bench drives both in one cycle and then reads the status a second time. The doorbell checks depend on a peer table that answers through a combinational lookup. The bench models that table with one peer whose vector count is zero and one peer at the maximum ID. This lets each bound be tested just inside and just outside its limit.

// File: rtl/shmdb_pkg.sv
package shmdb_pkg;
    parameter int DATA_W = 32;
    parameter int ADDR_W = 8;
    parameter int ID_W   = 16;
    parameter int VEC_W  = 8;
    localparam int CNT_W = VEC_W + 1;

    typedef enum logic [1:0] {
        SLOT_MASK   = 2'd0,
        SLOT_STATUS = 2'd1,
        SLOT_OWNID  = 2'd2,
        SLOT_BELL   = 2'd3
    } slot_e;

    typedef struct packed {
        logic [ID_W-1:0]  dest;
        logic [VEC_W-1:0] vec;
    } bell_t;

    // write decode: byte lanes [1:0] ignored
    function automatic logic wr_hit(logic [ADDR_W-1:0] a, slot_e s);
        return (a[ADDR_W-1:4] == '0) && (a[3:2] == s);
    endfunction

    // read decode: exact word offset only
    function automatic logic rd_hit(logic [ADDR_W-1:0] a, slot_e s);
        return wr_hit(a, s) && (a[1:0] == 2'b00);
    endfunction

    function automatic bell_t split_bell(logic [DATA_W-1:0] w);
        bell_t b;
        b.dest = w[DATA_W-1 -: ID_W];
        b.vec  = w[VEC_W-1:0];
        return b;
    endfunction
endpackage

// File: rtl/shmdb_intr.sv
module shmdb_intr
    import shmdb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              mask_we,
    input  logic              status_we,
    input  logic              status_rd,
    input  logic [DATA_W-1:0] wdata,
    input  logic              evt_valid,
    input  logic [DATA_W-1:0] evt_value,
    output logic [DATA_W-1:0] mask_q,
    output logic [DATA_W-1:0] status_q,
    output logic              irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q   <= '0;
            status_q <= '0;
        end else begin
            if (mask_we)
                mask_q <= wdata;
            if (evt_valid)
                status_q <= evt_value;
            else if (status_we)
                status_q <= wdata;
            else if (status_rd)
                status_q <= '0;
        end
    end

    assign irq = |(status_q & mask_q);
endmodule

// File: rtl/shmdb_bell.sv
module shmdb_bell
    import shmdb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bell_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [ID_W-1:0]   pt_query_id,
    input  logic [ID_W-1:0]   pt_max_id,
    input  logic [CNT_W-1:0]  pt_vec_count,
    output logic              notify_valid,
    output logic [ID_W-1:0]   notify_dest,
    output logic [VEC_W-1:0]  notify_vec
);
    bell_t req;
    logic  dest_ok, vec_ok, accept;

    assign req         = split_bell(wdata);
    assign pt_query_id = req.dest;
    assign dest_ok     = (req.dest <= pt_max_id);
    assign vec_ok      = ({1'b0, req.vec} < pt_vec_count);
    assign accept      = bell_we && dest_ok && vec_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            notify_valid <= 1'b0;
            notify_dest  <= '0;
            notify_vec   <= '0;
        end else begin
            notify_valid <= accept;
            if (accept) begin
                notify_dest <= req.dest;
                notify_vec  <= req.vec;
            end
        end
    end
endmodule

// File: rtl/shm_doorbell_regs.sv
module shm_doorbell_regs
    import shmdb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    input  logic [ID_W-1:0]   node_id,
    input  logic              mem_mapped,
    input  logic              evt_valid,
    input  logic [DATA_W-1:0] evt_value,
    output logic [ID_W-1:0]   pt_query_id,
    input  logic [ID_W-1:0]   pt_max_id,
    input  logic [CNT_W-1:0]  pt_vec_count,
    output logic              irq,
    output logic              notify_valid,
    output logic [ID_W-1:0]   notify_dest,
    output logic [VEC_W-1:0]  notify_vec
);
    logic              wr, rd;
    logic [DATA_W-1:0] mask_q, status_q, rd_mux;

    assign wr = acc_valid && acc_write;
    assign rd = acc_valid && !acc_write;

    shmdb_intr u_intr (
        .clk       (clk),
        .rst       (rst),
        .mask_we   (wr && wr_hit(acc_addr, SLOT_MASK)),
        .status_we (wr && wr_hit(acc_addr, SLOT_STATUS)),
        .status_rd (rd && rd_hit(acc_addr, SLOT_STATUS)),
        .wdata     (acc_wdata),
        .evt_valid (evt_valid),
        .evt_value (evt_value),
        .mask_q    (mask_q),
        .status_q  (status_q),
        .irq       (irq)
    );

    shmdb_bell u_bell (
        .clk          (clk),
        .rst          (rst),
        .bell_we      (wr && wr_hit(acc_addr, SLOT_BELL)),
        .wdata        (acc_wdata),
        .pt_query_id  (pt_query_id),
        .pt_max_id    (pt_max_id),
        .pt_vec_count (pt_vec_count),
        .notify_valid (notify_valid),
        .notify_dest  (notify_dest),
        .notify_vec   (notify_vec)
    );

    always_comb begin
        rd_mux = '0;
        if (rd_hit(acc_addr, SLOT_MASK))
            rd_mux = mask_q;
        else if (rd_hit(acc_addr, SLOT_STATUS))
            rd_mux = status_q;
        else if (rd_hit(acc_addr, SLOT_OWNID))
            rd_mux = mem_mapped ? DATA_W'(node_id) : '1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd;
            if (rd)
                rd_data <= rd_mux;
        end
    end
endmodule

// File: rtl/shmdb_chk.sv
module shmdb_chk
    import shmdb_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              acc_valid,
    input logic              acc_write,
    input logic [ADDR_W-1:0] acc_addr,
    input logic [DATA_W-1:0] acc_wdata,
    input logic              rd_valid,
    input logic [DATA_W-1:0] rd_data,
    input logic              mem_mapped,
    input logic              evt_valid,
    input logic [ID_W-1:0]   pt_max_id,
    input logic              irq,
    input logic              notify_valid
);
    // R12
    rd_after_access_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(acc_valid && !acc_write));

    // R8
    notify_source_chk: assert property (@(posedge clk) disable iff (rst)
        notify_valid |-> $past(acc_valid && acc_write && wr_hit(acc_addr, SLOT_BELL)));

    // R9
    dest_range_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_write && wr_hit(acc_addr, SLOT_BELL)
         && (acc_wdata[DATA_W-1 -: ID_W] > pt_max_id)) |=> !notify_valid);

    // R4
    read_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !acc_write && rd_hit(acc_addr, SLOT_STATUS) && !evt_valid) |=> !irq);

    // R6
    unmapped_id_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !acc_write && rd_hit(acc_addr, SLOT_OWNID) && !mem_mapped)
        |=> (rd_data == '1));
endmodule

bind shm_doorbell_regs shmdb_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .acc_valid    (acc_valid),
    .acc_write    (acc_write),
    .acc_addr     (acc_addr),
    .acc_wdata    (acc_wdata),
    .rd_valid     (rd_valid),
    .rd_data      (rd_data),
    .mem_mapped   (mem_mapped),
    .evt_valid    (evt_valid),
    .pt_max_id    (pt_max_id),
    .irq          (irq),
    .notify_valid (notify_valid)
);

// File: tb/sim_shm_doorbell_regs.sv
`timescale 1ns/1ps
module sim_shm_doorbell_regs;
    import shmdb_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              acc_valid = 1'b0, acc_write = 1'b0;
    logic [ADDR_W-1:0] acc_addr = '0;
    logic [DATA_W-1:0] acc_wdata = '0;
    logic              rd_valid;
    logic [DATA_W-1:0] rd_data;
    logic [ID_W-1:0]   node_id = 16'h0042;
    logic              mem_mapped = 1'b0;
    logic              evt_valid = 1'b0;
    logic [DATA_W-1:0] evt_value = '0;
    logic [ID_W-1:0]   pt_query_id;
    logic [ID_W-1:0]   pt_max_id = 16'd5;
    logic [CNT_W-1:0]  pt_vec_count;
    logic              irq, notify_valid;
    logic [ID_W-1:0]   notify_dest;
    logic [VEC_W-1:0]  notify_vec;

    int n_chk = 0, n_fail = 0;

    always #4 clk = ~clk;

    // peer table model: peer 3 has no vectors, others have id+1
    assign pt_vec_count = (pt_query_id == 16'd3) ? '0 : ({1'b0, pt_query_id[VEC_W-1:0]} + 1'b1);

    shm_doorbell_regs u0 (.*);

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        acc_valid = 1; acc_write = 1; acc_addr = a; acc_wdata = d;
        @(negedge clk);
        acc_valid = 0; acc_write = 0;
    endtask

    task automatic rdw(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        acc_valid = 1; acc_write = 0; acc_addr = a;
        @(negedge clk);
        d = rd_data;
        chk("R12 rd_valid", {31'd0, rd_valid}, 1);
        acc_valid = 0;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        chk("R1 irq", {31'd0, irq}, 0);
        chk("R1 notify", {31'd0, notify_valid}, 0);
        rdw(8'h00, d); chk("R1 mask", d, 0);
        rdw(8'h04, d); chk("R1 status", d, 0);
        @(negedge clk);
        chk("R12 rd_valid idle", {31'd0, rd_valid}, 0);
    endtask

    task automatic t_mask_status;
        logic [31:0] d;
        wr(8'h01, 32'h0000_00F0);
        rdw(8'h00, d); chk("R2 mask via 0x1", d, 32'h0000_00F0);
        chk("R3 irq low", {31'd0, irq}, 0);
        wr(8'h04, 32'h0000_000F);
        chk("R3 no overlap", {31'd0, irq}, 0);
        wr(8'h07, 32'h0000_0010);
        chk("R3 irq high", {31'd0, irq}, 1);
        rdw(8'h04, d); chk("R5 status value", d, 32'h10);
        chk("R4 irq dropped", {31'd0, irq}, 0);
        rdw(8'h04, d); chk("R4 cleared", d, 0);
        wr(8'h04, 32'h0000_0020);
        chk("R3 irq via status", {31'd0, irq}, 1);
        wr(8'h00, 32'h0);
        chk("R3 irq off via mask", {31'd0, irq}, 0);
        rdw(8'h04, d); chk("R4 status kept", d, 32'h20);
    endtask

    task automatic t_ownid;
        logic [31:0] d;
        mem_mapped = 0;
        rdw(8'h08, d); chk("R6 unmapped", d, 32'hFFFF_FFFF);
        mem_mapped = 1;
        rdw(8'h08, d); chk("R6 mapped", d, 32'h0000_0042);
    endtask

    task automatic t_undef;
        logic [31:0] d;
        wr(8'h00, 32'h0000_0003);
        wr(8'h04, 32'h0000_0001);
        rdw(8'h05, d); chk("R7 unaligned read", d, 0);
        rdw(8'h0C, d); chk("R7 bell read", d, 0);
        rdw(8'h40, d); chk("R7 high read", d, 0);
        wr(8'h10, 32'hFFFF_FFFF);
        wr(8'h80, 32'hFFFF_FFFF);
        rdw(8'h00, d); chk("R7 mask untouched", d, 32'h3);
        rdw(8'h04, d); chk("R7 status untouched", d, 32'h1);
    endtask

    task automatic bell(logic [15:0] dst, logic [7:0] vec, logic exp_ok, string req);
        @(negedge clk);
        acc_valid = 1; acc_write = 1; acc_addr = 8'h0C;
        acc_wdata = {dst, 8'hA5, vec};
        @(negedge clk);
        acc_valid = 0; acc_write = 0;
        chk(req, {31'd0, notify_valid}, {31'd0, exp_ok});
        if (exp_ok) begin
            chk("R8 dest", {16'd0, notify_dest}, {16'd0, dst});
            chk("R8 vec", {24'd0, notify_vec}, {24'd0, vec});
        end
        @(negedge clk);
        chk("R8 one cycle", {31'd0, notify_valid}, 0);
    endtask

    task automatic t_bell;
        bell(16'd2, 8'd2, 1, "R8 accept");
        bell(16'd5, 8'd0, 1, "R8 accept max id");
        bell(16'd6, 8'd0, 0, "R9 dest too high");
        bell(16'd2, 8'd3, 0, "R10 vec at count");
        bell(16'd3, 8'd0, 0, "R10 zero count");
    endtask

    task automatic t_event;
        logic [31:0] d;
        wr(8'h00, 32'h0000_0030);
        wr(8'h04, 32'h0000_000F);
        @(negedge clk);
        acc_valid = 1; acc_write = 0; acc_addr = 8'h04;
        evt_valid = 1; evt_value = 32'h30;
        @(negedge clk);
        acc_valid = 0; evt_valid = 0;
        chk("R11 old value read", rd_data, 32'h0F);
        chk("R11 irq from event", {31'd0, irq}, 1);
        rdw(8'h04, d); chk("R11 event kept", d, 32'h30);
        @(negedge clk);
        acc_valid = 1; acc_write = 1; acc_addr = 8'h04; acc_wdata = 32'h1;
        evt_valid = 1; evt_value = 32'h2;
        @(negedge clk);
        acc_valid = 0; acc_write = 0; evt_valid = 0;
        rdw(8'h04, d); chk("R11 event over write", d, 32'h2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_mask_status();
        t_ownid();
        t_undef();
        t_bell();
        t_event();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule